// File: doc/BRIEF.md
# Prioritized 64-Source Interrupt Controller

This block gathers 64 interrupt lines and presents a single request to a processor as a priority level plus a vector number. Each source has an 8-bit level register, and it has an enable bit that follows that register: a nonzero level turns the source on and a zero level turns it off. Every source also has one bit in each of three 64-bit registers. The pending register tracks the input line. The force register lets software raise the source. The mask register blocks the source. A source competes for the request when it is pending or forced, enabled, and unmasked.

Every clock cycle the controller picks the competing source with the largest level. When several sources share that level, the highest-numbered one wins. The registered outputs then show the winner's level and the vector `64 + index`. When nothing competes, the outputs show level 0 and the spurious vector 24. Software reaches the registers through a plain 32-bit read/write port that decodes an 8-bit byte address. There is no back-pressure on this port. A write is committed at the clock edge on which `bus_wr_i` is high. Read data is a combinational function of `bus_addr_i` and is valid in the same cycle.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the output level is 0 and the vector is 24. Every mask bit reads 1. Pending, force and all level registers read 0.
- R2: The pending bit of source n equals the level that input line n had at the previous clock edge. Pending reads back at byte offset 0x00 (sources 63..32) and at 0x04 (sources 31..0), with bit k of each word standing for the k-th source of that half.
- R3: A source competes only when (pending OR forced) AND enabled AND NOT masked.
- R4: Among competing sources the largest level wins. On equal levels the highest-numbered source wins.
- R5: The vector output is the winner index plus 64 and the level output is the winner's level. With no competitor the vector is 24 and the level is 0.
- R6: The level register of source n is at byte offset 0x40+n. A write stores wdata[7:0], and a read returns that value in rdata[7:0] with the upper bits zero.
- R7: Writing 0 to a level register disables that source. Writing a nonzero value enables it.
- R8: Writes to the pending offsets 0x00 and 0x04 have no effect.
- R9: The mask is written as two halves: high at 0x08 (sources 63..32) and low at 0x0C (sources 31..0). Each half reads back at its own offset, and writing one half leaves the other half unchanged.
- R10: The force register is written and read as two halves: high at 0x10 and low at 0x14. A forced source competes with its input line low.
- R11: A read of offset 0xE0 returns the current output vector in rdata[7:0], with the upper bits zero.
- R12: The outputs are registered. A change on an input line shows at the outputs after two clock edges. A register write shows at the outputs after one further edge following the edge that commits it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | 64 | Interrupt lines, one per source, active high |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Byte address within the register window |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, same cycle |
| irq_level_o | output | 8 | Priority level of the current request, 0 when idle |
| irq_vector_o | output | 8 | Vector of the current request, 24 when idle |

## Verification
A corrupted level, enable, mask or force bit shows up as a wrong vector or level at the outputs. It appears one edge after the state goes wrong, and only once the affected source is driven. For this reason the bench walks each source in turn through its input line and forces deliberate ties. A pending bit that is latched instead of tracking its line shows as a vector that stays up after the line drops, two edges later. A half-word write that spills into the other half shows on the next readback of that half.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int NSRC     = 64;
  localparam int IDX_W    = $clog2(NSRC);
  localparam int LVL_W    = 8;
  localparam int VEC_W    = 8;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 8;
  localparam int VEC_BASE = 64;
  localparam int VEC_SPUR = 24;

  localparam logic [ADDR_W-1:0] OFF_PEND_HI  = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_PEND_LO  = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_MASK_HI  = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_MASK_LO  = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_FORCE_HI = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_FORCE_LO = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_ACK      = 8'hE0;
  localparam logic [1:0]        LVL_PAGE     = 2'b01;
endpackage

// File: rtl/prio_irq_regs.sv
module prio_irq_regs
  import prio_irq_pkg::*;
#(
  parameter int LW = LVL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NSRC-1:0]    irq_i,
  input  logic               wr_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [VEC_W-1:0]   ack_vec_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [NSRC-1:0]    pend_o,
  output logic [NSRC-1:0]    force_o,
  output logic [NSRC-1:0]    mask_o,
  output logic [NSRC-1:0]    en_o,
  output logic [NSRC*LW-1:0] lvl_o
);
  localparam int HALF = NSRC / 2;

  logic [NSRC-1:0]  pend_q, frc_q, msk_q, en_q;
  logic [LW-1:0]    lvl_q [NSRC];
  logic             live_q;
  logic             lvl_hit;
  logic [IDX_W-1:0] lvl_idx;

  assign lvl_hit = (addr_i[ADDR_W-1:IDX_W] == LVL_PAGE);
  assign lvl_idx = addr_i[IDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      frc_q  <= '0;
      msk_q  <= '1;
      en_q   <= '0;
      live_q <= 1'b0;
      for (int i = 0; i < NSRC; i++) lvl_q[i] <= '0;
    end else begin
      pend_q <= irq_i;
      live_q <= 1'b1;
      if (wr_i) begin
        if (lvl_hit) begin
          lvl_q[lvl_idx] <= wdata_i[LW-1:0];
          en_q[lvl_idx]  <= |wdata_i[LW-1:0];
        end else begin
          case (addr_i)
            OFF_MASK_HI:  msk_q[NSRC-1:HALF] <= wdata_i[HALF-1:0];
            OFF_MASK_LO:  msk_q[HALF-1:0]    <= wdata_i[HALF-1:0];
            OFF_FORCE_HI: frc_q[NSRC-1:HALF] <= wdata_i[HALF-1:0];
            OFF_FORCE_LO: frc_q[HALF-1:0]    <= wdata_i[HALF-1:0];
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (lvl_hit) begin
      rdata_o[LW-1:0] = lvl_q[lvl_idx];
    end else begin
      case (addr_i)
        OFF_PEND_HI:  rdata_o[HALF-1:0] = pend_q[NSRC-1:HALF];
        OFF_PEND_LO:  rdata_o[HALF-1:0] = pend_q[HALF-1:0];
        OFF_MASK_HI:  rdata_o[HALF-1:0] = msk_q[NSRC-1:HALF];
        OFF_MASK_LO:  rdata_o[HALF-1:0] = msk_q[HALF-1:0];
        OFF_FORCE_HI: rdata_o[HALF-1:0] = frc_q[NSRC-1:HALF];
        OFF_FORCE_LO: rdata_o[HALF-1:0] = frc_q[HALF-1:0];
        OFF_ACK:      rdata_o[VEC_W-1:0] = ack_vec_i;
        default:      rdata_o = '0;
      endcase
    end
  end

  assign pend_o  = pend_q;
  assign force_o = frc_q;
  assign mask_o  = msk_q;
  assign en_o    = en_q;

  for (genvar g = 0; g < NSRC; g++) begin : g_lvl
    assign lvl_o[g*LW +: LW] = lvl_q[g];
  end

  AST_PEND_TRACKS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> (pend_q == $past(irq_i))); // R2
  AST_LEVEL_SETS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && lvl_hit) |=> (en_q[$past(lvl_idx)] == ($past(wdata_i[LW-1:0]) != '0))); // R7
  AST_MASK_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && addr_i == OFF_MASK_HI) |=> (msk_q[HALF-1:0] == $past(msk_q[HALF-1:0]))); // R9
  AST_MASK_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && addr_i == OFF_MASK_LO) |=> (msk_q[NSRC-1:HALF] == $past(msk_q[NSRC-1:HALF]))); // R9
endmodule

// File: rtl/prio_irq_arb.sv
module prio_irq_arb
  import prio_irq_pkg::*;
#(
  parameter int LW = LVL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NSRC-1:0]    active_i,
  input  logic [NSRC*LW-1:0] lvl_i,
  output logic               win_valid_o,
  output logic [IDX_W-1:0]   win_idx_o,
  output logic [LW-1:0]      win_lvl_o
);
  always_comb begin
    win_valid_o = 1'b0;
    win_idx_o   = '0;
    win_lvl_o   = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (active_i[i] && (lvl_i[i*LW +: LW] >= win_lvl_o)) begin
        win_valid_o = 1'b1;
        win_idx_o   = IDX_W'(i);
        win_lvl_o   = lvl_i[i*LW +: LW];
      end
    end
  end

  AST_WINNER_IS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid_o |-> active_i[win_idx_o]); // R3
  AST_WINNER_LEVEL_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid_o |-> (win_lvl_o != '0)); // R7
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NSRC-1:0]    irq_i,
  input  logic               bus_wr_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  output logic [LVL_W-1:0]   irq_level_o,
  output logic [VEC_W-1:0]   irq_vector_o
);
  logic [NSRC-1:0]       pend, frc, msk, en, active;
  logic [NSRC*LVL_W-1:0] lvl_flat;
  logic                  win_valid;
  logic [IDX_W-1:0]      win_idx;
  logic [LVL_W-1:0]      win_lvl;
  logic [LVL_W-1:0]      level_q;
  logic [VEC_W-1:0]      vec_q;

  prio_irq_regs #(.LW(LVL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_i),
    .wr_i(bus_wr_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .ack_vec_i(vec_q), .rdata_o(bus_rdata_o),
    .pend_o(pend), .force_o(frc), .mask_o(msk), .en_o(en), .lvl_o(lvl_flat)
  );

  assign active = (pend | frc) & en & ~msk;

  prio_irq_arb #(.LW(LVL_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .active_i(active), .lvl_i(lvl_flat),
    .win_valid_o(win_valid), .win_idx_o(win_idx), .win_lvl_o(win_lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
      vec_q   <= VEC_W'(VEC_SPUR);
    end else if (win_valid) begin
      level_q <= win_lvl;
      vec_q   <= VEC_W'(win_idx) + VEC_W'(VEC_BASE);
    end else begin
      level_q <= '0;
      vec_q   <= VEC_W'(VEC_SPUR);
    end
  end

  assign irq_level_o  = level_q;
  assign irq_vector_o = vec_q;

  AST_IDLE_PAIRING: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level_o == '0) == (irq_vector_o == VEC_W'(VEC_SPUR))); // R5
  AST_VECTOR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_vector_o == VEC_W'(VEC_SPUR)) ||
    ((irq_vector_o >= VEC_W'(VEC_BASE)) && (irq_vector_o < VEC_W'(VEC_BASE + NSRC)))); // R5
endmodule

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] irq = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  irq_level;
  logic [7:0]  irq_vector;

  int checks = 0;
  int errors = 0;

  logic [7:0]  m_lvl [64];
  logic [63:0] m_mask, m_force;

  always #4 clk = ~clk;

  prio_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .irq_i(irq),
    .bus_wr_i(bus_wr), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
    .bus_rdata_o(bus_rdata), .irq_level_o(irq_level), .irq_vector_o(irq_vector)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a >= 8'h40 && a < 8'h80) m_lvl[a - 8'h40] = d[7:0];
    if (a == 8'h08) m_mask[63:32] = d;
    if (a == 8'h0C) m_mask[31:0] = d;
    if (a == 8'h10) m_force[63:32] = d;
    if (a == 8'h14) m_force[31:0] = d;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [15:0] model();
    logic [7:0] bl = 0;
    logic       found = 0;
    logic [7:0] bi = 0;
    for (int i = 0; i < 64; i++) begin
      if ((irq[i] | m_force[i]) && (m_lvl[i] != 0) && !m_mask[i] && m_lvl[i] >= bl) begin
        bl = m_lvl[i]; bi = 8'(i); found = 1;
      end
    end
    return found ? {bl, bi + 8'd64} : {8'd0, 8'd24};
  endfunction

  task automatic chk_out(input string req);
    logic [15:0] e = model();
    logic [31:0] d;
    chk(req, {24'b0, irq_level}, {24'b0, e[15:8]});
    chk(req, {24'b0, irq_vector}, {24'b0, e[7:0]});
    rd(8'hE0, d);
    chk({req, " R11"}, d, {24'b0, e[7:0]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] s1, s2;
    for (int i = 0; i < 64; i++) m_lvl[i] = 0;
    m_mask = '1; m_force = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 level", {24'b0, irq_level}, 32'd0);
    chk("R1 vector", {24'b0, irq_vector}, 32'd24);
    rd(8'h08, d); chk("R1 mask hi", d, 32'hFFFF_FFFF);
    rd(8'h0C, d); chk("R1 mask lo", d, 32'hFFFF_FFFF);
    rd(8'h00, d); chk("R1 pend hi", d, 32'd0);
    rd(8'h14, d); chk("R1 force lo", d, 32'd0);
    for (int i = 0; i < 64; i++) begin
      rd(8'(8'h40 + i), d); chk("R1 level reg", d, 32'd0);
    end

    // R6 level registers, all sources
    for (int i = 0; i < 64; i++) wr(8'(8'h40 + i), 32'hABCD_EF00 | 32'((i % 7) + 1));
    for (int i = 0; i < 64; i++) begin
      rd(8'(8'h40 + i), d); chk("R6 level readback", d, 32'((i % 7) + 1));
    end
    wr(8'h08, 32'h0); wr(8'h0C, 32'h0);
    settle();
    chk_out("R3 nothing pending");

    // R2/R4/R5 walk each source alone
    for (int i = 0; i < 64; i++) begin
      irq = 64'd1 << i;
      settle();
      chk_out("R5 single source");
      rd(8'h00, d); chk("R2 pend hi", d, irq[63:32]);
      rd(8'h04, d); chk("R2 pend lo", d, irq[31:0]);
    end

    // R12 latency: line rises, outputs two edges later
    irq = '0; settle();
    irq = 64'd1 << 5;
    @(negedge clk);
    chk("R12 after one edge", {24'b0, irq_vector}, 32'd24);
    @(negedge clk);
    chk("R12 after two edges", {24'b0, irq_vector}, 32'd69);
    // R12 write latency: level change shows one edge after commit
    wr(8'h45, 32'd3);
    chk("R12 write not yet", {24'b0, irq_level}, 32'(5 % 7 + 1));
    @(negedge clk);
    chk("R12 write visible", {24'b0, irq_level}, 32'd3);
    // R2 pending not latched
    irq = '0; settle();
    chk_out("R2 line dropped");

    // R4 ties and priority
    wr(8'h4A, 32'd5); wr(8'h68, 32'd5);
    irq = (64'd1 << 10) | (64'd1 << 40);
    settle();
    chk("R4 tie higher index", {24'b0, irq_vector}, 32'd104);
    wr(8'h43, 32'd9); wr(8'h7C, 32'd2);
    irq = (64'd1 << 3) | (64'd1 << 60);
    settle();
    chk("R4 larger level wins", {24'b0, irq_vector}, 32'd67);
    chk("R5 level", {24'b0, irq_level}, 32'd9);

    // R9 mask halves
    irq = (64'd1 << 10) | (64'd1 << 40);
    wr(8'h0C, 32'h0000_0F00);
    wr(8'h08, 32'h0000_0100);
    rd(8'h0C, d); chk("R9 lo kept", d, 32'h0000_0F00);
    rd(8'h08, d); chk("R9 hi", d, 32'h0000_0100);
    wr(8'h0C, 32'h0);
    rd(8'h08, d); chk("R9 hi kept", d, 32'h0000_0100);
    settle();
    chk("R9 masked source loses", {24'b0, irq_vector}, 32'd74);
    wr(8'h08, 32'h0);

    // R10 force
    irq = '0;
    wr(8'h14, 32'h0000_0080);
    wr(8'h10, 32'h0000_0002);
    rd(8'h14, d); chk("R10 force lo", d, 32'h0000_0080);
    rd(8'h10, d); chk("R10 force hi", d, 32'h0000_0002);
    settle();
    chk_out("R10 forced source");
    wr(8'h10, 32'h0); wr(8'h14, 32'h0);

    // R7 zero level disables
    irq = 64'd1 << 3;
    settle();
    chk("R7 enabled", {24'b0, irq_vector}, 32'd67);
    wr(8'h43, 32'h0000_0100);
    settle();
    chk("R7 zero disables", {24'b0, irq_vector}, 32'd24);
    chk("R7 zero level out", {24'b0, irq_level}, 32'd0);
    wr(8'h43, 32'd1);
    settle();
    chk("R7 nonzero enables", {24'b0, irq_vector}, 32'd67);

    // R8 pending writes ignored
    irq = '0;
    wr(8'h04, 32'hFFFF_FFFF); wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h04, d); chk("R8 pend lo", d, 32'd0);
    rd(8'h00, d); chk("R8 pend hi", d, 32'd0);
    settle();
    chk("R8 vector", {24'b0, irq_vector}, 32'd24);

    // R3/R4 pseudo-random sweep
    s1 = 32'h1234_5678; s2 = 32'h9ABC_DEF1;
    for (int k = 0; k < 60; k++) begin
      s1 = s1 ^ (s1 << 13); s1 = s1 ^ (s1 >> 17); s1 = s1 ^ (s1 << 5);
      s2 = s2 ^ (s2 << 13); s2 = s2 ^ (s2 >> 17); s2 = s2 ^ (s2 << 5);
      irq = {s1 & s2, s1 | s2};
      wr(8'h08, s2 & 32'h5555_5555);
      wr(8'h0C, s1 & 32'hAAAA_AAAA);
      wr(8'h14, s1 & 32'h0101_0101);
      wr(8'(8'h40 + (s2 % 64)), {24'b0, 8'(s1[7:0] & 8'h0F)});
      settle();
      chk_out("R3 R4 sweep");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule